// File: doc/BRIEF.md
# Power-State Output Level Controller

This block drives two active-low power-control pins whose levels follow the system power state. An external decoder supplies the state as a two-bit code: normal running, S3 sleep, S5 soft-off, or the condition after AC power loss. For each of the three non-running states, software chooses the level of each pin separately by writing a level register. A separate enable register holds a master enable for the whole feature and a sticky flag that records a return from S3.

When the feature is disabled, or the system is running, both pins rest high (inactive). The pin levels are registered, so a change of state or of register contents reaches the pins at the next clock edge without glitches. Access for software is a plain one-cycle write strobe with a one-bit register select. Readback is combinational and follows the select. All pins are plain control and status signals with no handshake.

Top module: `pwr_level_ctl`

## Requirements
- R1: After reset the level register reads 0x0C, the enable register reads 0x00 and both `ctl_n` bits are 1.
- R2: A write with `reg_sel`=1 stores `reg_wdata[5:0]` into the level register. Bit 5 is the S3 level of pin 1, bit 4 the S3 level of pin 0, bit 3 the S5 level of pin 1, bit 2 the S5 level of pin 0, bit 1 the after-AC-loss level of pin 1 and bit 0 the after-AC-loss level of pin 0. Bits 7:6 read 0 and ignore writes.
- R3: A write with `reg_sel`=0 stores `reg_wdata[7]` as the master enable. Bits 5:0 of the enable register read 0 and ignore writes.
- R4: At the clock edge that samples a master enable of 0, or `pstate`=0 (running), both `ctl_n` bits become 1.
- R5: With the feature enabled and `pstate`=1 (S3), at the next edge `ctl_n[0]` takes level bit 4 and `ctl_n[1]` takes level bit 5.
- R6: With the feature enabled and `pstate`=2 (S5), at the next edge `ctl_n[0]` takes level bit 2 and `ctl_n[1]` takes level bit 3.
- R7: With the feature enabled and `pstate`=3 (after AC loss), at the next edge `ctl_n[0]` takes level bit 0 and `ctl_n[1]` takes level bit 1.
- R8: A cycle with `s3_resume`=1 sets bit 6 of the enable register at that edge. The bit then stays set.
- R9: A write to the enable register with bit 6 = 1 clears the resume flag. A write with bit 6 = 0 leaves it unchanged.
- R10: When `s3_resume` and a clearing write occur in the same cycle, the flag ends up set.
- R11: `ctl_n` is registered. A register write at edge k affects `ctl_n` at edge k+1, and a `pstate` value present before edge k affects `ctl_n` at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pstate | input | 2 | Power state: 0 running, 1 S3, 2 S5, 3 after AC loss |
| s3_resume | input | 1 | Pulse marking a return from S3 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 enable, 1 level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected register |
| ctl_n | output | 2 | Active-low control pin levels |

## Verification
Two functions can land in the same cycle: the hardware setting of the resume flag, and software clearing it through a write to the enable register. The bench drives `s3_resume` together with a write of bit 6 = 1, both alone and mixed with random traffic. It judges the outcome from the flag read back after that edge, which must be set. A second overlap is a level-register write while the state is changing. There the bench model expects the pins to use the old levels for one edge and the new levels after it.

// File: rtl/pwr_lvl_pkg.sv
package pwr_lvl_pkg;
  typedef enum logic [1:0] {
    PS_RUN = 2'd0,
    PS_S3  = 2'd1,
    PS_S5  = 2'd2,
    PS_ACL = 2'd3
  } pstate_e;

  localparam logic SEL_ENA = 1'b0;
  localparam logic SEL_LVL = 1'b1;
endpackage

// File: rtl/pwr_lvl_regs.sv
module pwr_lvl_regs #(
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   sel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   resume,
  output logic [3*NUM_OUT-1:0]   lvl,
  output logic                   feat_en,
  output logic                   resume_flag,
  output logic [DATA_W-1:0]      rdata
);
  import pwr_lvl_pkg::*;

  localparam int LVL_W   = 3 * NUM_OUT;
  localparam int EN_BIT  = DATA_W - 1;
  localparam int FLG_BIT = DATA_W - 2;
  localparam logic [LVL_W-1:0] LVL_RST =
    {{NUM_OUT{1'b0}}, {NUM_OUT{1'b1}}, {NUM_OUT{1'b0}}};

  logic wr_lvl, wr_ena, flag_clr;
  logic [DATA_W-1:0] ena_word, lvl_word;

  assign wr_lvl   = wr && (sel == SEL_LVL);
  assign wr_ena   = wr && (sel == SEL_ENA);
  assign flag_clr = wr_ena && wdata[FLG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= LVL_RST;
    end else if (wr_lvl) begin
      lvl <= wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_en <= 1'b0;
    end else if (wr_ena) begin
      feat_en <= wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_flag <= 1'b0;
    end else if (resume) begin
      resume_flag <= 1'b1;
    end else if (flag_clr) begin
      resume_flag <= 1'b0;
    end
  end

  always_comb begin
    ena_word          = '0;
    ena_word[EN_BIT]  = feat_en;
    ena_word[FLG_BIT] = resume_flag;
    lvl_word          = '0;
    lvl_word[LVL_W-1:0] = lvl;
    rdata = (sel == SEL_LVL) ? lvl_word : ena_word;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> resume_flag); // R10

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_flag && !(wr && sel == SEL_ENA && wdata[FLG_BIT])) |=> resume_flag); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!resume && wr && sel == SEL_ENA && wdata[FLG_BIT]) |=> !resume_flag); // R9

  AST_LVL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_LVL) |=> $stable(lvl)); // R2
endmodule

// File: rtl/pwr_lvl_select.sv
module pwr_lvl_select #(
  parameter int NUM_OUT = 2
) (
  input  pwr_lvl_pkg::pstate_e   st,
  input  logic                   feat_en,
  input  logic [3*NUM_OUT-1:0]   lvl,
  output logic [NUM_OUT-1:0]     want_n
);
  import pwr_lvl_pkg::*;

  localparam int ACL_BASE = 0;
  localparam int S5_BASE  = NUM_OUT;
  localparam int S3_BASE  = 2 * NUM_OUT;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    always_comb begin
      want_n[i] = 1'b1;
      if (feat_en) begin
        unique case (st)
          PS_S3:   want_n[i] = lvl[S3_BASE + i];
          PS_S5:   want_n[i] = lvl[S5_BASE + i];
          PS_ACL:  want_n[i] = lvl[ACL_BASE + i];
          default: want_n[i] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwr_lvl_outreg.sv
module pwr_lvl_outreg #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] want_n,
  output logic [NUM_OUT-1:0] pin_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_n <= '1;
    end else begin
      pin_n <= want_n;
    end
  end
endmodule

// File: rtl/pwr_level_ctl.sv
module pwr_level_ctl #(
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pstate,
  input  logic              s3_resume,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_OUT-1:0] ctl_n
);
  import pwr_lvl_pkg::*;

  localparam int LVL_W = 3 * NUM_OUT;

  pstate_e            st;
  logic [LVL_W-1:0]   lvl;
  logic               feat_en;
  logic               resume_flag;
  logic [NUM_OUT-1:0] want_n;

  assign st = pstate_e'(pstate);

  pwr_lvl_regs #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .resume(s3_resume), .lvl(lvl), .feat_en(feat_en),
    .resume_flag(resume_flag), .rdata(reg_rdata)
  );

  pwr_lvl_select #(.NUM_OUT(NUM_OUT)) u_sel (
    .st(st), .feat_en(feat_en), .lvl(lvl), .want_n(want_n)
  );

  pwr_lvl_outreg #(.NUM_OUT(NUM_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .want_n(want_n), .pin_n(ctl_n)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_en || st == PS_RUN) |=> (ctl_n == '1)); // R4

  AST_S3_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && st == PS_S3) |=> (ctl_n == $past(lvl[3*NUM_OUT-1:2*NUM_OUT]))); // R5

  AST_S5_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && st == PS_S5) |=> (ctl_n == $past(lvl[2*NUM_OUT-1:NUM_OUT]))); // R6

  AST_ACL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && st == PS_ACL) |=> (ctl_n == $past(lvl[NUM_OUT-1:0]))); // R7

  AST_ENA_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_ENA) |-> (reg_rdata[DATA_W-3:0] == '0)); // R3
endmodule

// File: tb/sim_pwr_level_ctl.sv
module sim_pwr_level_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pstate = 2'd0;
  logic       s3_resume = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] ctl_n;

  int total = 0;
  int bad = 0;

  // reference model state
  bit       m_en = 0;
  bit       m_flag = 0;
  bit [5:0] m_lvl = 6'h0C;
  bit [1:0] m_out = 2'b11;
  string    out_tag = "R4";
  string    flg_tag = "R8";

  always #10 clk = ~clk;

  pwr_level_ctl u0 (
    .clk(clk), .rst_n(rst_n), .pstate(pstate), .s3_resume(s3_resume),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctl_n(ctl_n)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    check({out_tag, " R11 ctl_n"}, ctl_n, m_out);
    if (reg_sel) begin
      exp_rd = {2'b00, m_lvl};
      check("R2 level readback", reg_rdata, exp_rd);
    end else begin
      exp_rd = {m_en, 7'd0};
      check("R3 enable readback", {reg_rdata[7], 1'b0, reg_rdata[5:0]}, exp_rd);
      check({flg_tag, " resume flag"}, reg_rdata[6], m_flag);
    end
  endtask

  // one clock: model update at posedge, compare at negedge
  task automatic tick();
    bit [1:0] nxt;
    bit clr;
    @(posedge clk);
    nxt = 2'b11;
    out_tag = "R4";
    if (m_en) begin
      case (pstate)
        2'd1: begin nxt = {m_lvl[5], m_lvl[4]}; out_tag = "R5"; end
        2'd2: begin nxt = {m_lvl[3], m_lvl[2]}; out_tag = "R6"; end
        2'd3: begin nxt = {m_lvl[1], m_lvl[0]}; out_tag = "R7"; end
        default: ;
      endcase
    end
    m_out = nxt;
    clr = reg_wr && !reg_sel && reg_wdata[6];
    if (s3_resume && clr) flg_tag = "R10";
    else if (clr) flg_tag = "R9";
    else flg_tag = "R8";
    if (s3_resume) m_flag = 1;
    else if (clr) m_flag = 0;
    if (reg_wr && reg_sel) m_lvl = reg_wdata[5:0];
    if (reg_wr && !reg_sel) m_en = reg_wdata[7];
    @(negedge clk);
    compare();
  endtask

  task automatic wr(bit sel, bit [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    reg_sel = 1;
    #1 check("R1 level reset", reg_rdata, 8'h0C);
    reg_sel = 0;
    #1 check("R1 enable reset", reg_rdata, 8'h00);
    check("R1 ctl_n reset", ctl_n, 2'b11);
    rst_n = 1;
    idle(2);

    // disabled feature: states have no effect (R4)
    for (int s = 0; s < 4; s++) begin pstate = 2'(s); idle(2); end

    // R2 reserved bits ignore writes
    wr(1, 8'hFF); reg_sel = 1; idle(1);
    wr(1, 8'b1110_0110); reg_sel = 1; idle(1);
    // R3 enable with reserved bits written, flag clear bit 0
    wr(0, 8'hBF); idle(1);

    // R5..R7, R11 per state with two level patterns
    for (int s = 0; s < 4; s++) begin pstate = 2'(s); idle(2); end
    wr(1, 8'b0001_1001);
    for (int s = 3; s >= 0; s--) begin pstate = 2'(s); idle(2); end
    // R11: write while in S5, change visible an edge later
    pstate = 2'd2; idle(1);
    wr(1, 8'b0011_0011); idle(2);

    // R8 set and hold, R9 clear
    s3_resume = 1; tick(); s3_resume = 0; idle(3);
    wr(0, 8'h80); idle(1);
    wr(0, 8'hC0); idle(1);
    // R10 set and clear together
    s3_resume = 1; wr(0, 8'hC0); s3_resume = 0; idle(2);

    // disable again while in S3 (R4)
    pstate = 2'd1; wr(0, 8'h00); idle(2);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      pstate    = 2'($urandom_range(0, 3));
      s3_resume = ($urandom_range(0, 7) == 0);
      reg_sel   = 1'($urandom_range(0, 1));
      reg_wdata = 8'($urandom_range(0, 255));
      reg_wr    = ($urandom_range(0, 3) == 0);
      tick();
    end
    reg_wr = 0; s3_resume = 0;
    idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule